// File: doc/BRIEF.md
# Cascadable Output Serializer

This block turns a parallel word into a serial bit stream. The word is sampled on the rising edge of a slow divided clock. The bits are then shifted out on a fast clock. In single-rate mode the block sends one bit per fast cycle. In double-rate mode it sends one bit in each half of the fast cycle. A second, narrower path serializes an output-enable (3-state) word, and that path has its own rate setting. It can be a plain pass-through, one bit held for the whole word, or four bits sent at double rate.

One instance can handle words of up to six bits. A wider word needs two instances. The role parameter sets one instance as master, which is the default, and the other as slave. The master takes the low six bits of the word and the slave takes the rest. The slave's cascade output connects to the master's cascade input. As the master's shift register drains, the slave's bits move into the top of the master's register, so the master's serial pin carries the whole word. The two clocks must be phase-aligned. The divided clock must run at exactly one rising edge per word.

Top module: `par2ser_cascade`

## Requirements
- R1: Legal data widths are 2 to 8 in single-rate mode, and 4, 6, 8 or 10 in double-rate mode. The 3-state width must be 1 in pass-through or single-rate 3-state mode. It must be 4 in double-rate 3-state mode, which also requires double-rate data of width 4. A slave is legal only when the total width exceeds 6. Any other configuration fails an elaboration-time assertion.
- R2: For a total width W above 6, the master takes word bits 5..0 and the slave takes bits W-1..6. The master's serial output carries bits 6..W-1 directly after bit 5, and the master inserts no idle slot between them.
- R3: Bits leave least-significant first. In single-rate mode bit j of a word is on `ser_q` during fast cycle E+2+j, where E is the fast edge that coincides with the divided-clock edge that sampled the word.
- R4: In double-rate mode, bit 2k is on `ser_q` while `clk_fast` is high after edge E+2+k. Bit 2k+1 is on `ser_q` during the low half that follows.
- R5: A word sampled at divided edge E starts at fast edge E+2. Consecutive words follow with no gap, so bit 0 of the next word comes right after the last bit of the current word.
- R6: In single-rate 3-state mode, `par_ts[0]` of a word drives `ser_tq` for all fast cycles of that word's data, aligned with its first data bit.
- R7: In double-rate 3-state mode, the 4 bits of `par_ts` are serialized with the data timing: bit 0 on the rising half and bit 1 on the falling half after E+2, then bits 2 and 3 after E+3.
- R8: In pass-through 3-state mode, `ser_tq` follows `par_ts[0]` with no register.
- R9: Reset is synchronous and active high. While reset is held, and until the first word's first bit, `ser_q` is 0. In the registered 3-state modes `ser_tq` is 1 (driver disabled) over the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock |
| clk_div | input | 1 | Word-rate clock, rising edges aligned with `clk_fast` |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | LANE_W | This instance's share of the parallel word |
| par_ts | input | TS_W | Parallel 3-state word |
| casc_in | input | 2 | Bits from the slave, used by a cascaded master |
| casc_out | output | 2 | Low bits of the shift register, sent to the master |
| ser_q | output | 1 | Serial data |
| ser_tq | output | 1 | Serial 3-state control, 1 = driver off |

## Verification
The assertions assume three things about the inputs:
- `clk_div` rises on a `clk_fast` rising edge.
- `clk_div` rises exactly once per word period, with the period counted in fast cycles.
- Each word is steady around the divided edge that samples it.

The word-period check fails if the clock ratio is wrong. The bench derives both clocks from one timebase and sets the divided half-period to the word's step count times half a fast period. It changes data, 3-state words and reset 1 ns after a divided falling edge, away from every fast edge. It releases reset between two divided edges, so the first word is sampled cleanly.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

  typedef enum logic [1:0] {
    TS_BUF = 2'd0,
    TS_SDR = 2'd1,
    TS_DDR = 2'd2
  } ts_rate_e;

  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;

  // Largest share a single instance serializes on its own
  localparam int unsigned CASCADE_SPLIT = 6;

  function automatic bit data_width_ok(bit ddr, int unsigned dw);
    if (ddr) return (dw == 4) || (dw == 6) || (dw == 8) || (dw == 10);
    return (dw >= 2) && (dw <= 8);
  endfunction

  function automatic bit ts_width_ok(ts_rate_e r, int unsigned tsw, bit ddr, int unsigned dw);
    if (r == TS_DDR) return (tsw == 4) && ddr && (dw <= 4);
    return tsw == 1;
  endfunction

  function automatic int unsigned lane_width(role_e r, int unsigned dw);
    if (r == ROLE_SLAVE) return (dw > CASCADE_SPLIT) ? dw - CASCADE_SPLIT : 1;
    return (dw > CASCADE_SPLIT) ? CASCADE_SPLIT : dw;
  endfunction

  function automatic int unsigned word_steps(bit ddr, int unsigned dw);
    return ddr ? dw / 2 : dw;
  endfunction

endpackage

// File: rtl/ser_word_capture.sv
`timescale 1ns/1ps
module ser_word_capture #(
  parameter int unsigned DW    = 4,
  parameter int unsigned TW    = 1,
  parameter int unsigned STEPS = 4
) (
  input  logic          clk_fast,
  input  logic          clk_div,
  input  logic          rst,
  input  logic [DW-1:0] d_in,
  input  logic [TW-1:0] t_in,
  output logic [DW-1:0] d_word,
  output logic [TW-1:0] t_word,
  output logic          load
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};

  logic div_tog;
  logic fast_seen;

  // Divided-clock side: hold the word, flip a marker per capture
  always_ff @(posedge clk_div) begin
    if (rst) begin
      d_word  <= '0;
      t_word  <= '1;
      div_tog <= 1'b0;
    end else begin
      d_word  <= d_in;
      t_word  <= t_in;
      div_tog <= ~div_tog;
    end
  end

  // Fast side: a marker mismatch means a fresh word is waiting
  always_ff @(posedge clk_fast) begin
    if (rst) fast_seen <= 1'b0;
    else     fast_seen <= div_tog;
  end

  assign load = div_tog ^ fast_seen;

  // Fast cycles since the last transfer, for the clock-ratio check
  logic [CNT_W-1:0] gap_cnt;
  logic             armed;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      gap_cnt <= '0;
      armed   <= 1'b0;
    end else if (load) begin
      gap_cnt <= '0;
      armed   <= 1'b1;
    end else if (gap_cnt != GAP_MAX) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_word_period_R5: assert property (@(posedge clk_fast) disable iff (rst)
    (load && armed) |-> (gap_cnt == GAP_END));

endmodule

// File: rtl/ser_shift_lane.sv
`timescale 1ns/1ps
module ser_shift_lane #(
  parameter int unsigned LW      = 4,
  parameter int unsigned STEP    = 1,
  parameter logic        RST_BIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] word,
  input  logic [1:0]    fill,
  output logic [1:0]    low
);
  logic [LW-1:0] sr;
  logic [LW+1:0] joined;
  logic [LW+1:0] moved;

  // Fill bits enter at the top as the register drains from bit 0
  assign joined = {fill, sr};
  assign moved  = joined >> STEP;

  always_ff @(posedge clk) begin
    if (rst)       sr <= {LW{RST_BIT}};
    else if (load) sr <= word;
    else           sr <= moved[LW-1:0];
  end

  logic [1:0] unused_moved;
  assign unused_moved = moved[LW+1:LW];

  if (LW >= 2) begin : g_wide
    assign low = sr[1:0];
  end else begin : g_narrow
    assign low = {1'b0, sr[0]};
  end

  assert_load_word_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (sr == $past(word)));

endmodule

// File: rtl/ser_out_stage.sv
`timescale 1ns/1ps
module ser_out_stage #(
  parameter bit   DDR     = 1'b0,
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_bit,
  input  logic fall_bit,
  output logic q
);
  logic rise_q;

  always_ff @(posedge clk) begin
    if (rst) rise_q <= RST_BIT;
    else     rise_q <= rise_bit;
  end

  if (DDR) begin : g_ddr
    logic fall_hold;
    logic fall_q;

    always_ff @(posedge clk) begin
      if (rst) fall_hold <= RST_BIT;
      else     fall_hold <= fall_bit;
    end

    always_ff @(negedge clk) begin
      if (rst) fall_q <= RST_BIT;
      else     fall_q <= fall_hold;
    end

    // High half shows the rising bit, low half the falling bit
    assign q = clk ? rise_q : fall_q;
  end else begin : g_sdr
    logic unused_fall;
    assign unused_fall = fall_bit;
    assign q = rise_q;
  end

endmodule

// File: rtl/par2ser_cascade.sv
`timescale 1ns/1ps
module par2ser_cascade
  import ser_pkg::*;
#(
  parameter bit          DDR_MODE = 1'b0,
  parameter int unsigned DATA_W   = 4,
  parameter ts_rate_e    TS_RATE  = TS_SDR,
  parameter int unsigned TS_W     = 1,
  parameter role_e       ROLE     = ROLE_MASTER,
  localparam int unsigned LANE_W  = lane_width(ROLE, DATA_W)
) (
  input  logic              clk_fast,
  input  logic              clk_div,
  input  logic              rst,
  input  logic [LANE_W-1:0] par_data,
  input  logic [TS_W-1:0]   par_ts,
  input  logic [1:0]        casc_in,
  output logic [1:0]        casc_out,
  output logic              ser_q,
  output logic              ser_tq
);
  localparam int unsigned STEP  = DDR_MODE ? 2 : 1;
  localparam int unsigned STEPS = word_steps(DDR_MODE, DATA_W);
  localparam bit LEGAL = data_width_ok(DDR_MODE, DATA_W)
                      && ts_width_ok(TS_RATE, TS_W, DDR_MODE, DATA_W)
                      && ((ROLE == ROLE_MASTER) || (DATA_W > CASCADE_SPLIT));

  initial begin : cfg_check
    assert_legal_cfg_R1: assert (LEGAL)
      else $error("serializer: width %0d / rate / 3-state / role combination not allowed", DATA_W);
  end

  logic [LANE_W-1:0] d_word;
  logic [TS_W-1:0]   t_word;
  logic              load;
  logic [1:0]        fill;
  logic [1:0]        d_low;

  ser_word_capture #(
    .DW   (LANE_W),
    .TW   (TS_W),
    .STEPS(STEPS)
  ) u_capture (
    .clk_fast(clk_fast),
    .clk_div (clk_div),
    .rst     (rst),
    .d_in    (par_data),
    .t_in    (par_ts),
    .d_word  (d_word),
    .t_word  (t_word),
    .load    (load)
  );

  // Only a master of a wide word takes bits from the slave
  if ((ROLE == ROLE_MASTER) && (DATA_W > CASCADE_SPLIT)) begin : g_fill_casc
    assign fill = casc_in;
  end else begin : g_fill_zero
    logic [1:0] unused_casc;
    assign unused_casc = casc_in;
    assign fill = 2'b00;
  end

  ser_shift_lane #(
    .LW     (LANE_W),
    .STEP   (STEP),
    .RST_BIT(1'b0)
  ) u_data_lane (
    .clk (clk_fast),
    .rst (rst),
    .load(load),
    .word(d_word),
    .fill(fill),
    .low (d_low)
  );

  assign casc_out = DDR_MODE ? d_low : {1'b0, d_low[0]};

  ser_out_stage #(
    .DDR    (DDR_MODE),
    .RST_BIT(1'b0)
  ) u_data_out (
    .clk     (clk_fast),
    .rst     (rst),
    .rise_bit(d_low[0]),
    .fall_bit(d_low[1]),
    .q       (ser_q)
  );

  if (TS_RATE == TS_BUF) begin : g_ts_buf
    logic [TS_W-1:0] unused_tw;
    assign unused_tw = t_word;
    assign ser_tq = par_ts[0];
  end else if (TS_RATE == TS_SDR) begin : g_ts_sdr
    logic t_hold;
    always_ff @(posedge clk_fast) begin
      if (rst)       t_hold <= 1'b1;
      else if (load) t_hold <= t_word[0];
    end
    ser_out_stage #(
      .DDR    (1'b0),
      .RST_BIT(1'b1)
    ) u_ts_out (
      .clk     (clk_fast),
      .rst     (rst),
      .rise_bit(t_hold),
      .fall_bit(1'b1),
      .q       (ser_tq)
    );
  end else begin : g_ts_ddr
    logic [1:0] t_low;
    ser_shift_lane #(
      .LW     (TS_W),
      .STEP   (2),
      .RST_BIT(1'b1)
    ) u_ts_lane (
      .clk (clk_fast),
      .rst (rst),
      .load(load),
      .word(t_word),
      .fill(2'b11),
      .low (t_low)
    );
    ser_out_stage #(
      .DDR    (1'b1),
      .RST_BIT(1'b1)
    ) u_ts_out (
      .clk     (clk_fast),
      .rst     (rst),
      .rise_bit(t_low[0]),
      .fall_bit(t_low[1]),
      .q       (ser_tq)
    );
  end

  if (TS_RATE == TS_BUF) begin : g_rst_chk_buf
    assert_reset_out_R9: assert property (@(posedge clk_fast) disable iff (rst)
      $fell(rst) |-> (ser_q == 1'b0));
  end else begin : g_rst_chk_reg
    assert_reset_out_R9: assert property (@(posedge clk_fast) disable iff (rst)
      $fell(rst) |-> (ser_q == 1'b0 && ser_tq == 1'b1));
  end

endmodule

// File: tb/ser_harness.sv
`timescale 1ns/1ps
module ser_harness #(
  parameter bit                DDR  = 1'b0,
  parameter int unsigned       W    = 5,
  parameter ser_pkg::ts_rate_e TSR  = ser_pkg::TS_SDR,
  parameter int unsigned       TSW  = 1,
  parameter int unsigned       NW   = 40,
  parameter int unsigned       SEED = 1,
  parameter string             NAME = "cfg"
) (
  input  logic clk,
  output int   checks,
  output int   errs,
  output logic done
);
  import ser_pkg::*;

  localparam int unsigned S    = DDR ? W / 2 : W;
  localparam int unsigned MAXE = (NW + 8) * S + 16;
  localparam int unsigned RST_END = 3 * S + 2;

  logic           divclk = 1'b0;
  logic           rst    = 1'b1;
  logic [W-1:0]   d      = '0;
  logic [TSW-1:0] t      = '1;
  logic           q, tq;

  logic er[MAXE], ef[MAXE], tr[MAXE], tf[MAXE];
  bit   er_v[MAXE], ef_v[MAXE], tr_v[MAXE], tf_v[MAXE];
  int   ir[MAXE], ifl[MAXE];

  if (W > 6) begin : g_casc
    logic [1:0] link;
    logic [1:0] unused_co;
    logic       q_s, tq_s;
    par2ser_cascade #(.DDR_MODE(DDR), .DATA_W(W), .TS_RATE(TSR), .TS_W(TSW), .ROLE(ROLE_MASTER)) u_dut (
      .clk_fast(clk), .clk_div(divclk), .rst(rst), .par_data(d[5:0]), .par_ts(t),
      .casc_in(link), .casc_out(unused_co), .ser_q(q), .ser_tq(tq));
    par2ser_cascade #(.DDR_MODE(DDR), .DATA_W(W), .TS_RATE(TSR), .TS_W(TSW), .ROLE(ROLE_SLAVE)) u_slave (
      .clk_fast(clk), .clk_div(divclk), .rst(rst), .par_data(d[W-1:6]), .par_ts(t),
      .casc_in(2'b00), .casc_out(link), .ser_q(q_s), .ser_tq(tq_s));
  end else begin : g_single
    logic [1:0] unused_co;
    par2ser_cascade #(.DDR_MODE(DDR), .DATA_W(W), .TS_RATE(TSR), .TS_W(TSW), .ROLE(ROLE_MASTER)) u_dut (
      .clk_fast(clk), .clk_div(divclk), .rst(rst), .par_data(d), .par_ts(t),
      .casc_in(2'b00), .casc_out(unused_co), .ser_q(q), .ser_tq(tq));
  end

  // Divided clock: rising edges land on fast rising edges, one per word
  initial begin
    #2.5;
    forever begin
      divclk = 1'b1;
      #(S * 2.5);
      divclk = 1'b0;
      #(S * 2.5);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [%s] %s: actual %b expected %b", req, NAME, what, act, exp);
    end
  endtask

  function automatic string bit_tag(int idx);
    if (idx == 0) return "R5";
    if (idx >= 6) return "R2";
    return DDR ? "R4" : "R3";
  endfunction

  function automatic string ts_tag();
    return (TSR == TS_DDR) ? "R7" : "R6";
  endfunction

  initial begin
    int unsigned r;
    checks = 0;
    errs   = 0;
    done   = 1'b0;
    r = $urandom(SEED);
    for (int i = 0; i < int'(NW) + 4; i++) begin
      @(negedge divclk);
      #1;
      if (i == 2) rst = 1'b0;
      case (i)
        2:       d = '1;
        3:       d = '0;
        4:       for (int b = 0; b < int'(W); b++) d[b] = b[0];
        default: d = W'($urandom);
      endcase
      t = TSW'($urandom);
      if (!rst) begin
        int e;
        e = (i + 1) * int'(S);
        for (int j = 0; j < int'(W); j++) begin
          int n;
          n = DDR ? e + 2 + j / 2 : e + 2 + j;
          if (!DDR || (j % 2 == 0)) begin
            er[n] = d[j]; er_v[n] = 1'b1; ir[n] = j;
          end else begin
            ef[n] = d[j]; ef_v[n] = 1'b1; ifl[n] = j;
          end
        end
        if (TSR == TS_SDR) begin
          for (int k = 0; k < int'(S); k++) begin
            tr[e + 2 + k] = t[0]; tr_v[e + 2 + k] = 1'b1;
            tf[e + 2 + k] = t[0]; tf_v[e + 2 + k] = 1'b1;
          end
        end else if (TSR == TS_DDR) begin
          for (int j = 0; j < int'(TSW); j++) begin
            if (j % 2 == 0) begin
              tr[e + 2 + j / 2] = t[j]; tr_v[e + 2 + j / 2] = 1'b1;
            end else begin
              tf[e + 2 + j / 2] = t[j]; tf_v[e + 2 + j / 2] = 1'b1;
            end
          end
        end
      end
    end
    repeat (3 * S + 4) @(posedge clk);
    done = 1'b1;
  end

  task automatic look(input int n, input bit fall);
    logic ev, tv;
    bit   evv, tvv;
    int   idx;
    ev  = fall ? ef[n] : er[n];
    evv = fall ? ef_v[n] : er_v[n];
    idx = fall ? ifl[n] : ir[n];
    tv  = fall ? tf[n] : tr[n];
    tvv = fall ? tf_v[n] : tr_v[n];
    if (evv) chk(q === ev, bit_tag(idx), fall ? "data low half" : "data high half", q, ev);
    else if (n >= 1 && n < int'(RST_END)) chk(q === 1'b0, "R9", "idle data", q, 1'b0);
    if (TSR == TS_BUF) chk(tq === t[0], "R8", "3-state pass-through", tq, t[0]);
    else if (tvv) chk(tq === tv, ts_tag(), "3-state bit", tq, tv);
    else if (n >= 1 && n < int'(RST_END)) chk(tq === 1'b1, "R9", "idle 3-state", tq, 1'b1);
  endtask

  // Sample 1.25 ns into each half of the fast clock
  initial begin
    for (int n = 0; n < int'(MAXE); n++) begin
      @(posedge clk);
      #1.25;
      look(n, 1'b0);
      if (DDR) begin
        #2.5;
        look(n, 1'b1);
      end
    end
  end

endmodule

// File: tb/par2ser_cascade_tb.sv
`timescale 1ns/1ps
module par2ser_cascade_tb;
  import ser_pkg::*;

  logic clk = 1'b0;
  initial forever #2.5 clk = ~clk;

  int   ca, cb, cc, cd, ea, eb, ec, ed;
  logic da, db, dc, dd;
  int   own_chk = 0;
  int   own_err = 0;

  ser_harness #(.DDR(1'b0), .W(5),  .TSR(TS_SDR), .TSW(1), .SEED(11), .NAME("sdr5"))
    h_a (.clk(clk), .checks(ca), .errs(ea), .done(da));
  ser_harness #(.DDR(1'b1), .W(4),  .TSR(TS_DDR), .TSW(4), .SEED(23), .NAME("ddr4"))
    h_b (.clk(clk), .checks(cb), .errs(eb), .done(db));
  ser_harness #(.DDR(1'b0), .W(8),  .TSR(TS_BUF), .TSW(1), .SEED(37), .NAME("sdr8"))
    h_c (.clk(clk), .checks(cc), .errs(ec), .done(dc));
  ser_harness #(.DDR(1'b1), .W(10), .TSR(TS_SDR), .TSW(1), .SEED(41), .NAME("ddr10"))
    h_d (.clk(clk), .checks(cd), .errs(ed), .done(dd));

  task automatic own(input bit act, input bit exp, input string what);
    own_chk++;
    if (act != exp) begin
      own_err++;
      $display("FAIL R1 %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  initial begin
    int cyc;
    // R1: legality table, computed here from the requirement
    for (int w = 1; w <= 12; w++) begin
      for (int r = 0; r < 2; r++) begin
        bit exp;
        exp = (r == 1) ? (w == 4 || w == 6 || w == 8 || w == 10) : (w >= 2 && w <= 8);
        own(data_width_ok(r[0], w), exp, $sformatf("data width %0d rate %0d", w, r));
      end
    end
    own(ts_width_ok(TS_DDR, 4, 1'b1, 4), 1'b1, "3-state ddr 4 with ddr data 4");
    own(ts_width_ok(TS_DDR, 4, 1'b1, 6), 1'b0, "3-state ddr 4 with data 6");
    own(ts_width_ok(TS_DDR, 4, 1'b0, 4), 1'b0, "3-state ddr with sdr data");
    own(ts_width_ok(TS_SDR, 4, 1'b0, 4), 1'b0, "3-state sdr width 4");
    own(ts_width_ok(TS_BUF, 1, 1'b0, 8), 1'b1, "3-state pass width 1");

    cyc = 0;
    while (!(da === 1'b1 && db === 1'b1 && dc === 1'b1 && dd === 1'b1) && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 200000) begin
      own_chk++;
      own_err++;
      $display("FAIL R5 watchdog: actual not done expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors",
             own_chk + ca + cb + cc + cd, own_err + ea + eb + ec + ed);
    $finish;
  end

endmodule